// File: doc/BRIEF.md
# Relative Branch Resolver

This block settles a conditional relative branch in one step. Given an instruction byte, a signed byte offset, the address of the instruction that follows the branch, and four status flags, it reports three things. It says whether the byte is a branch at all and, if so, whether the branch is taken. It gives the program counter to continue from. It gives the number of cycles the branch costs.

A sequencer that has already fetched the instruction and its offset presents them here and uses the result directly. The flag to test and the required sense of that flag are both decoded from the instruction byte.

The cost model reflects a machine with 256-byte pages. A branch that is not taken costs two cycles. A taken branch costs three cycles, or four when its target lands in a different page than the fall-through address.

The logic is combinational. A parameter can add one register stage on all outputs.

Top module: `branch_resolver`

## Requirements
- R1: `valid_o` is 1 exactly when `opcode_i[4:0]` equals 5'b10000; every other byte is not a branch.
- R2: `opcode_i[7:6]` picks the tested flag from `flags_i`: 0 tests bit 0 (negative), 1 tests bit 1 (overflow), 2 tests bit 2 (carry), 3 tests bit 3 (zero).
- R3: A branch is taken when the tested flag equals `opcode_i[5]`: with bit 5 set it needs the flag set, with bit 5 clear it needs the flag clear.
- R4: For a taken branch, `pc_o` is `pc_next_i` plus `disp_i` read as a two's-complement byte.
- R5: For a branch that is not taken, `pc_o` equals `pc_next_i` and `cycles_o` is 2.
- R6: A taken branch costs 3 cycles when `pc_o[15:8]` equals `pc_next_i[15:8]`, and 4 cycles when they differ.
- R7: For a non-branch byte, `valid_o`, `taken_o` and `cycles_o` are 0 and `pc_o` equals `pc_next_i`.
- R8: With `REG_OUT` set (the default), every output shows the result for the inputs present at the previous rising clock edge. While `rst_n` is low, all outputs are 0.
- R9: Target arithmetic wraps modulo 2^16 in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low synchronous reset of the output stage |
| opcode_i | input | 8 | Instruction byte under test |
| disp_i | input | 8 | Signed byte offset |
| pc_next_i | input | 16 | Address of the instruction after the branch |
| flags_i | input | 4 | Status flags {zero, carry, overflow, negative} |
| valid_o | output | 1 | Instruction byte is a branch |
| taken_o | output | 1 | Branch condition holds |
| pc_o | output | 16 | Address to continue from |
| cycles_o | output | 3 | Cycle cost: 2, 3 or 4; 0 for a non-branch |

## Verification
Every one of the eight branch forms is driven once with its flag set and once with it clear. This separates a wrong flag selection from a wrong polarity.

Offsets are chosen to cover several cases:
- forward and backward moves that stay in the page;
- moves that step into the next or previous page;
- moves that wrap past address 0xFFFF or 0x0000.

Together these distinguish a sign-extension fault from a page-comparison fault.

A sweep over all 256 instruction bytes with varied flags and offsets confirms that only the branch pattern is recognised. It also confirms that non-branch bytes stay quiet, while the result changes on every clock so that the register stage is checked back to back.

// File: rtl/branch_res_pkg.sv
package branch_res_pkg;

  localparam int OPC_W   = 8;
  localparam int SEL_W   = 2;
  localparam int NFLAGS  = 1 << SEL_W;
  localparam int CYC_W   = 3;

  // Low five opcode bits that mark a relative branch
  localparam logic [4:0] BR_PATTERN = 5'b10000;

  typedef enum logic [SEL_W-1:0] {
    SEL_NEG   = 2'd0,
    SEL_OVF   = 2'd1,
    SEL_CARRY = 2'd2,
    SEL_ZERO  = 2'd3
  } flag_sel_e;

  typedef struct packed {
    logic      is_branch;
    flag_sel_e sel;
    logic      want_set;
  } br_decode_t;

  localparam logic [CYC_W-1:0] COST_BASE = CYC_W'(2);

endpackage

// File: rtl/bru_decode.sv
module bru_decode
  import branch_res_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  output br_decode_t       dec_o
);

  always_comb begin
    dec_o.is_branch = (opcode_i[4:0] == BR_PATTERN);
    dec_o.sel       = flag_sel_e'(opcode_i[7:6]);
    dec_o.want_set  = opcode_i[5];
  end

endmodule

// File: rtl/bru_target.sv
module bru_target #(
  parameter int PC_W      = 16,
  parameter int DISP_W    = 8,
  parameter int PAGE_BITS = 8
) (
  input  logic [PC_W-1:0]   base_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic [PC_W-1:0]   target_o,
  output logic              cross_o
);

  localparam int EXT_W = PC_W - DISP_W;

  function automatic logic [PC_W-1:0] rel_add(input logic [PC_W-1:0] base,
                                              input logic [DISP_W-1:0] d);
    logic [PC_W-1:0] ext;
    ext = {{EXT_W{d[DISP_W-1]}}, d};
    return base + ext;
  endfunction

  function automatic logic page_differs(input logic [PC_W-1:0] a,
                                        input logic [PC_W-1:0] b);
    return a[PC_W-1:PAGE_BITS] != b[PC_W-1:PAGE_BITS];
  endfunction

  always_comb begin
    target_o = rel_add(base_i, disp_i);
    cross_o  = page_differs(target_o, base_i);
  end

endmodule

// File: rtl/bru_cost.sv
module bru_cost
  import branch_res_pkg::*;
(
  input  logic             valid_i,
  input  logic             taken_i,
  input  logic             cross_i,
  output logic [CYC_W-1:0] cycles_o
);

  function automatic logic [CYC_W-1:0] cost(input logic v, input logic t,
                                            input logic x);
    logic [CYC_W-1:0] c;
    c = '0;
    if (v) begin
      c = COST_BASE;
      if (t) c = c + CYC_W'(1);
      if (t && x) c = c + CYC_W'(1);
    end
    return c;
  endfunction

  always_comb cycles_o = cost(valid_i, taken_i, cross_i);

endmodule

// File: rtl/branch_resolver.sv
module branch_resolver
  import branch_res_pkg::*;
#(
  parameter int PC_W      = 16,
  parameter int DISP_W    = 8,
  parameter int PAGE_BITS = 8,
  parameter bit REG_OUT   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OPC_W-1:0]  opcode_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [PC_W-1:0]   pc_next_i,
  input  logic [NFLAGS-1:0] flags_i,
  output logic              valid_o,
  output logic              taken_o,
  output logic [PC_W-1:0]   pc_o,
  output logic [CYC_W-1:0]  cycles_o
);

  br_decode_t        dec_w;
  logic              flag_hit_w;
  logic              cond_met_w;
  logic [PC_W-1:0]   target_w;
  logic              cross_w;
  logic              valid_c;
  logic              taken_c;
  logic [PC_W-1:0]   pc_c;
  logic [CYC_W-1:0]  cycles_c;

  bru_decode u_decode (
    .opcode_i (opcode_i),
    .dec_o    (dec_w)
  );

  bru_target #(
    .PC_W      (PC_W),
    .DISP_W    (DISP_W),
    .PAGE_BITS (PAGE_BITS)
  ) u_target (
    .base_i   (pc_next_i),
    .disp_i   (disp_i),
    .target_o (target_w),
    .cross_o  (cross_w)
  );

  always_comb begin
    flag_hit_w = flags_i[dec_w.sel];
    cond_met_w = (flag_hit_w == dec_w.want_set);
    valid_c    = dec_w.is_branch;
    taken_c    = dec_w.is_branch && cond_met_w;
    pc_c       = taken_c ? target_w : pc_next_i;
  end

  bru_cost u_cost (
    .valid_i  (valid_c),
    .taken_i  (taken_c),
    .cross_i  (cross_w),
    .cycles_o (cycles_c)
  );

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          valid_o  <= 1'b0;
          taken_o  <= 1'b0;
          pc_o     <= '0;
          cycles_o <= '0;
        end else begin
          valid_o  <= valid_c;
          taken_o  <= taken_c;
          pc_o     <= pc_c;
          cycles_o <= cycles_c;
        end
      end

      a_r8_stage_delay: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (valid_o == $past(valid_c) && taken_o == $past(taken_c) &&
                   pc_o == $past(pc_c) && cycles_o == $past(cycles_c)));
    end else begin : g_comb
      always_comb begin
        valid_o  = valid_c;
        taken_o  = taken_c;
        pc_o     = pc_c;
        cycles_o = cycles_c;
      end
    end
  endgenerate

  a_r3_sense_match: assert property (@(posedge clk) disable iff (!rst_n)
    taken_c |-> (flags_i[opcode_i[7:6]] == opcode_i[5] && opcode_i[4:0] == 5'b10000));

  a_r5_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_c && !taken_c) |-> (pc_c == pc_next_i && cycles_c == CYC_W'(2)));

  a_r6_long_cost: assert property (@(posedge clk) disable iff (!rst_n)
    (cycles_c == CYC_W'(4)) |-> (taken_c && cross_w));

  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_c |-> (!taken_c && cycles_c == '0 && pc_c == pc_next_i));

endmodule

// File: tb/test_branch_resolver.sv
`timescale 1ns/1ps
module test_branch_resolver;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  opcode_i = 8'h00;
  logic [7:0]  disp_i = 8'h00;
  logic [15:0] pc_next_i = 16'h0000;
  logic [3:0]  flags_i = 4'h0;
  logic        valid_o;
  logic        taken_o;
  logic [15:0] pc_o;
  logic [2:0]  cycles_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  branch_resolver i_branch_resolver (
    .clk       (clk),
    .rst_n     (rst_n),
    .opcode_i  (opcode_i),
    .disp_i    (disp_i),
    .pc_next_i (pc_next_i),
    .flags_i   (flags_i),
    .valid_o   (valid_o),
    .taken_o   (taken_o),
    .pc_o      (pc_o),
    .cycles_o  (cycles_o)
  );

  // Behavioural reference built from the requirements
  task automatic model(input int op, input int d, input int pc, input int fl,
                       output int e_v, output int e_t, output int e_pc,
                       output int e_c);
    int sd;
    int f;
    int tgt;
    e_v = ((op % 32) == 16) ? 1 : 0;
    f = (fl >> (op / 64)) % 2;
    e_t = (e_v == 1 && f == ((op / 32) % 2)) ? 1 : 0;
    sd = (d >= 128) ? d - 256 : d;
    tgt = (pc + sd + 65536) % 65536;
    e_pc = (e_t == 1) ? tgt : pc;
    if (e_v == 0) e_c = 0;
    else if (e_t == 0) e_c = 2;
    else if ((tgt / 256) != (pc / 256)) e_c = 4;
    else e_c = 3;
  endtask

  task automatic compare(input string tag, input int e_v, input int e_t,
                         input int e_pc, input int e_c);
    n_checks++;
    if (int'(valid_o) != e_v || int'(taken_o) != e_t ||
        int'(pc_o) != e_pc || int'(cycles_o) != e_c) begin
      n_fail++;
      $display("FAIL %s: got v=%0d t=%0d pc=%04h cyc=%0d, want v=%0d t=%0d pc=%04h cyc=%0d",
               tag, valid_o, taken_o, pc_o, cycles_o, e_v, e_t, e_pc, e_c);
    end
  endtask

  // Drive at a falling edge, let one rising edge capture, check at next fall
  task automatic apply(input string tag, input int op, input int d,
                       input int pc, input int fl);
    int e_v;
    int e_t;
    int e_pc;
    int e_c;
    model(op, d, pc, fl, e_v, e_t, e_pc, e_c);
    opcode_i  = 8'(op);
    disp_i    = 8'(d);
    pc_next_i = 16'(pc);
    flags_i   = 4'(fl);
    @(posedge clk);
    @(negedge clk);
    compare(tag, e_v, e_t, e_pc, e_c);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout, want completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    // R8: reset holds outputs at zero even with a taken branch applied
    opcode_i = 8'hB0; disp_i = 8'h10; pc_next_i = 16'h4000; flags_i = 4'hF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R8 reset", 0, 0, 0, 0);
    rst_n = 1'b1;

    // R2 R3: every branch form with its flag set and clear
    for (int s = 0; s < 4; s++) begin
      for (int p = 0; p < 2; p++) begin
        int op;
        op = s * 64 + p * 32 + 16;
        apply("R2 R3 flag set", op, 8'h05, 16'h2100, 1 << s);
        apply("R2 R3 flag clear", op, 8'h05, 16'h2100, 15 - (1 << s));
      end
    end

    // R4 R6: in-page forward and backward
    apply("R4 fwd in page", 8'hB0, 8'h20, 16'h3010, 4'h4);
    apply("R4 back in page", 8'hB0, 8'hF0, 16'h3080, 4'h4);
    // R6: page cross forward and backward
    apply("R6 cross fwd", 8'hB0, 8'h7F, 16'h30C0, 4'h4);
    apply("R6 cross back", 8'hB0, 8'h80, 16'h3010, 4'h4);
    apply("R6 edge stay", 8'hB0, 8'h01, 16'h30FE, 4'h4);
    apply("R6 edge cross", 8'hB0, 8'h01, 16'h30FF, 4'h4);
    // R9: wrap both ways
    apply("R9 wrap up", 8'hF0, 8'h10, 16'hFFF8, 4'h8);
    apply("R9 wrap down", 8'hF0, 8'hF0, 16'h0004, 4'h8);
    // R5: not taken with a crossing offset still costs 2
    apply("R5 not taken", 8'h90, 8'h7F, 16'h30C0, 4'h4);
    // R7: non-branch bytes near the pattern
    apply("R7 near miss a", 8'h11, 8'h10, 16'h5000, 4'hF);
    apply("R7 near miss b", 8'h14, 8'h10, 16'h5000, 4'h0);
    apply("R7 near miss c", 8'h00, 8'h10, 16'h5000, 4'hF);

    // R1: full sweep over all instruction bytes
    for (int op = 0; op < 256; op++) begin
      apply("R1 sweep", op, (op * 37) % 256, 16'h1280 + op * 97, (op ^ 5) % 16);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule